// File: doc/BRIEF.md
# Bit-slice population counter

The block returns how many bits are set in a 32-bit word. It does not sum the bits one by one. It works in parallel bit slices. First it forms a 2-bit count for each bit pair, then a 4-bit count for each nibble, then a count for each byte. The four byte counts are then merged into one total.

A build parameter chooses how the byte counts are merged: a multiply whose top byte holds the sum, or a plain sum of the four byte lanes. The two choices give the same result. A second parameter places an optional register stage at the output.

The input word comes with a valid strobe. The 6-bit count leaves the block with a matching valid. A consumer can place the block straight in a combinational path, or spend one cycle of latency to shorten the logic depth.

Top module: `swar_popcount`

## Requirements
- R1: `count_o` equals the number of set bits of the 32-bit `data_i` it was formed from, for every input value.
- R2: An all-zero word gives a count of 0, and an all-ones word gives a count of 32. `count_o` is 6 bits wide and never exceeds 32.
- R3: With `REGISTERED`=1, `valid_o` in each cycle equals `valid_i` of the previous cycle.
- R4: With `REGISTERED`=1, a word presented with `valid_i`=1 has its count on `count_o` one clock edge later.
- R5: With `REGISTERED`=1, in a cycle with `valid_i`=0 the count register does not load, so `count_o` keeps its previous value.
- R6: With `REGISTERED`=1, while `rst_ni` is low, `valid_o` is 0 and `count_o` is 0.
- R7: The multiply-based merge (`USE_MULT`=1) and the lane-sum merge (`USE_MULT`=0) give bit-identical counts for the same word.
- R8: With `REGISTERED`=0, `count_o` and `valid_o` follow `data_i` and `valid_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word is valid |
| data_i | input | 32 | Word whose set bits are counted |
| valid_o | output | 1 | Count is valid |
| count_o | output | 6 | Number of set bits, 0 to 32 |

## Verification
The bench builds two instances side by side and drives them with the same stimulus.

One instance uses `REGISTERED`=1 with the multiply merge. It exposes the cycle of latency, the hold when `valid_i` is low, and the reset values.

The other uses `REGISTERED`=0 with the lane-sum merge. It is checked in the same cycle as its input.

Comparing the two instances word by word shows that the two merge variants agree. The patterns are zero, all-ones, single bits at both ends, alternating bits, and random words.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int LANES  = WORD_W / 8;

  localparam logic [WORD_W-1:0] M_PAIR   = 32'h5555_5555;
  localparam logic [WORD_W-1:0] M_NIBBLE = 32'h3333_3333;
  localparam logic [WORD_W-1:0] M_BYTE   = 32'h0F0F_0F0F;
  localparam logic [WORD_W-1:0] M_SPREAD = 32'h0101_0101;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/popcnt_slices.sv
module popcnt_slices
  import popcnt_pkg::*;
(
  input  word_t word_i,
  output word_t bytes_o
);
  word_t pair_cnt, nib_cnt;

  always_comb begin
    pair_cnt = word_i - ((word_i >> 1) & M_PAIR);
    nib_cnt  = (pair_cnt & M_NIBBLE) + ((pair_cnt >> 2) & M_NIBBLE);
    bytes_o  = (nib_cnt + (nib_cnt >> 4)) & M_BYTE;
  end

  // each 2-bit field counts at most 2, each byte lane at most 8
  always_comb begin
    if (!$isunknown(word_i)) begin
      for (int k = 0; k < WORD_W / 2; k++)
        assert_pair_le2_R1: assert (pair_cnt[2*k +: 2] <= 2'd2);
      for (int k = 0; k < LANES; k++)
        assert_byte_le8_R1: assert (bytes_o[8*k +: 8] <= 8'd8);
    end
  end
endmodule

// File: rtl/popcnt_merge.sv
module popcnt_merge
  import popcnt_pkg::*;
#(
  parameter bit USE_MULT = 1'b1
) (
  input  word_t bytes_i,
  output cnt_t  cnt_o
);
  generate
    if (USE_MULT) begin : g_mult
      word_t prod;
      always_comb begin
        prod  = bytes_i * M_SPREAD;
        cnt_o = CNT_W'(prod >> (WORD_W - 8));
      end
    end else begin : g_lanes
      always_comb begin
        cnt_o = '0;
        for (int k = 0; k < LANES; k++)
          cnt_o = cnt_o + CNT_W'(bytes_i[8*k +: 8]);
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown(bytes_i))
      assert_cnt_max_R2: assert (cnt_o <= CNT_W'(WORD_W));
  end
endmodule

// File: rtl/popcnt_out_stage.sv
module popcnt_out_stage
  import popcnt_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  cnt_t cnt_i,
  output logic valid_o,
  output cnt_t cnt_o
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o <= 1'b0;
          cnt_o   <= '0;
        end else begin
          valid_o <= valid_i;
          if (valid_i) cnt_o <= cnt_i;
        end
      end

      assert_valid_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o);
      assert_valid_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o);
      assert_count_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (cnt_o == $past(cnt_i)));
      assert_count_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(cnt_o));
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign valid_o = valid_i;
      assign cnt_o   = cnt_i;
    end
  endgenerate
endmodule

// File: rtl/swar_popcount.sv
module swar_popcount
  import popcnt_pkg::*;
#(
  parameter bit REGISTERED = 1'b1,
  parameter bit USE_MULT   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  count_o
);
  word_t byte_cnts;
  cnt_t  total;

  popcnt_slices u_slices (
    .word_i  (data_i),
    .bytes_o (byte_cnts)
  );

  popcnt_merge #(.USE_MULT(USE_MULT)) u_merge (
    .bytes_i (byte_cnts),
    .cnt_o   (total)
  );

  popcnt_out_stage #(.REGISTERED(REGISTERED)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .cnt_i   (total),
    .valid_o (valid_o),
    .cnt_o   (count_o)
  );

  always_comb begin
    if (!$isunknown(data_i) && data_i == '0)
      assert_zero_word_R2: assert (total == '0);
  end
endmodule

// File: tb/swar_popcount_test.sv
module swar_popcount_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] data = '0;
  logic        vo_r, vo_c;
  logic [5:0]  cnt_r, cnt_c;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  swar_popcount #(.REGISTERED(1'b1), .USE_MULT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .valid_o(vo_r), .count_o(cnt_r));

  swar_popcount #(.REGISTERED(1'b0), .USE_MULT(1'b0)) uut_comb (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .valid_o(vo_c), .count_o(cnt_c));

  function automatic int ref_count(logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(w[i]);
    return n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int held = 0;

  // drive at negedge, check comb at once, registered after next posedge
  task automatic apply(logic [31:0] w, logic v);
    int e = ref_count(w);
    @(negedge clk);
    data = w; valid = v;
    #1;
    check(cnt_c == 6'(e), "R1 comb count", int'(cnt_c), e);
    check(vo_c == v, "R8 comb valid", int'(vo_c), int'(v));
    @(posedge clk); #1;
    check(vo_r == v, "R3 reg valid", int'(vo_r), int'(v));
    if (v) begin
      check(cnt_r == 6'(e), "R4 reg count", int'(cnt_r), e);
      check(cnt_r == cnt_c, "R7 mult vs lanes", int'(cnt_r), int'(cnt_c));
      held = e;
    end else begin
      check(cnt_r == 6'(held), "R5 hold on idle", int'(cnt_r), held);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(vo_r == 1'b0, "R6 reset valid", int'(vo_r), 0);
    check(cnt_r == 6'd0, "R6 reset count", int'(cnt_r), 0);
    rst_n = 1'b1;

    apply(32'h0000_0000, 1'b1);
    check(cnt_r == 6'd0, "R2 zero word", int'(cnt_r), 0);
    apply(32'hFFFF_FFFF, 1'b1);
    check(cnt_r == 6'd32, "R2 all ones", int'(cnt_r), 32);
    apply(32'h0000_0001, 1'b1);
    apply(32'h8000_0000, 1'b1);
    apply(32'hAAAA_AAAA, 1'b1);
    apply(32'h5555_5555, 1'b1);
    apply(32'h0F0F_0F0F, 1'b1);
    apply(32'hFF00_00FF, 1'b1);
    apply(32'hFFFF_FFFF, 1'b1);
    apply(32'h1234_5678, 1'b0);
    apply(32'h0000_0000, 1'b0);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w = $urandom;
      if (i % 7 == 3) w = w & $urandom;
      if (i % 11 == 5) w = w | $urandom;
      apply(w, ($urandom % 4) != 0);
    end

    @(negedge clk);
    valid = 1'b1; data = 32'hFFFF_FFFF;
    rst_n = 1'b0;
    #1;
    check(vo_r == 1'b0, "R6 async reset valid", int'(vo_r), 0);
    check(cnt_r == 6'd0, "R6 async reset count", int'(cnt_r), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule